// File: doc/BRIEF.md
# FM Tuning Word Calculator

This block produces one phase-increment word per audio sample for a direct digital synthesizer, so that the synthesizer output becomes a frequency-modulated carrier. Each incoming sample, delivered as an unsigned offset-binary code with a one-cycle strobe, is turned into a signed deviation. The deviation is multiplied by a programmable gain in hertz per sample step and added to a programmable centre frequency.

The resulting frequency in hertz is mapped onto the synthesizer's 32-bit tuning word for a 180 MHz reference clock, where one word step is 180e6 / 2^32, about 0.0419 Hz. All arithmetic is fixed-point. The conversion multiplies by a precomputed reciprocal constant that carries extra fraction bits, and then rounds those bits away. Frequencies outside the range the synthesizer can produce are clamped, and a flag marks each clamped result. At audio rates of 20 to 40 kHz, the four-cycle pipeline is idle almost all the time, but it accepts a new sample on every cycle.

Top module: `fm_tuning_word`

## Requirements
- R1: The sample is offset binary. Code 0x800 means zero deviation, and code c gives the signed step count d = c - 2048, so 0x000 is -2048 and 0xFFF is +2047.
- R2: The frequency is f = centre + d * gain, with centre and gain read as unsigned integers in hertz and in hertz per step. Centre and gain are taken in the same cycle as the sample.
- R3: When 0 <= f <= 90,000,000, the word is floor((f * K + 2^23) / 2^24), where K = round(2^56 / 180,000,000) = 400,319,967, and the saturation flag is 0.
- R4: When f < 0, the word is 0 and the saturation flag is 1.
- R5: When f > 90,000,000, the word is 0x8000_0000 and the saturation flag is 1. The value f = 90,000,000 itself is not saturated.
- R6: out_valid is a single-cycle pulse that comes exactly 4 rising edges after the edge that captures in_valid. It pulses once per accepted sample and never without one.
- R7: out_word and out_sat hold their values between results. Changes on the sample, centre or gain inputs while in_valid is low have no effect on them.
- R8: While reset is held, and afterwards until the first result, out_valid, out_word and out_sat are all 0.
- R9: Samples on consecutive cycles produce results on consecutive cycles, in the order the samples arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Offset-binary audio sample |
| in_centre | input | 28 | Centre frequency in Hz |
| in_gain | input | 16 | Deviation gain in Hz per sample step |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | Synthesizer tuning word |
| out_sat | output | 1 | Result was clamped |

## Verification
Every result appears four rising edges after the edge that captures its strobe: one edge each for scaling, summing with clamping, the constant multiply, and rounding into the output register. The single-sample tasks drive inputs on a falling edge and wait four rising edges. They then check the word, the flag and the strobe just after that edge, and check one edge later that the strobe has dropped while the word is held. The streaming task drives a new sample on every falling edge and compares, at each falling edge, the output with the expected value for the sample driven four falling edges earlier.

// File: rtl/fm_tw_pkg.sv
package fm_tw_pkg;
  // round(2^(word_w+frac_w) / ref_hz): hertz-to-word scale with frac_w guard bits
  function automatic longint unsigned tw_scale_const(longint unsigned ref_hz,
                                                     int unsigned word_w,
                                                     int unsigned frac_w);
    longint unsigned num;
    num = 64'd1 << (word_w + frac_w);
    return (num + ref_hz / 2) / ref_hz;
  endfunction
endpackage

// File: rtl/fm_tw_scale.sv
module fm_tw_scale #(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 16,
  parameter int FREQ_W   = 28,
  localparam int DEV_W   = SAMPLE_W + GAIN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [SAMPLE_W-1:0]     in_sample,
  input  logic [GAIN_W-1:0]       in_gain,
  input  logic [FREQ_W-1:0]       in_centre,
  output logic                    s1_valid,
  output logic signed [DEV_W-1:0] s1_dev,
  output logic [FREQ_W-1:0]       s1_centre
);
  localparam logic [SAMPLE_W-1:0] MID_CODE = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic signed [SAMPLE_W-1:0] samp_tc;
  logic signed [DEV_W-1:0]    samp_ext, gain_ext, dev_nx;

  // offset binary to two's complement: flip the top bit
  always_comb begin
    samp_tc  = {~in_sample[SAMPLE_W-1], in_sample[SAMPLE_W-2:0]};
    samp_ext = {{(DEV_W-SAMPLE_W){samp_tc[SAMPLE_W-1]}}, samp_tc};
    gain_ext = {{(DEV_W-GAIN_W){1'b0}}, in_gain};
    dev_nx   = samp_ext * gain_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_dev    <= '0;
      s1_centre <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_dev    <= dev_nx;
        s1_centre <= in_centre;
      end
    end
  end

  // R1: mid-scale code yields zero deviation
  p_mid_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample == MID_CODE) |=> (s1_dev == '0));
  // R1: gain of zero never produces deviation
  p_gain_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_gain == '0) |=> (s1_dev == '0));
endmodule

// File: rtl/fm_tw_clamp.sv
module fm_tw_clamp #(
  parameter int FREQ_W = 28,
  parameter int DEV_W  = 29,
  parameter logic [FREQ_W-1:0] HALF_HZ = FREQ_W'(90_000_000),
  localparam int SUM_W = ((FREQ_W > DEV_W) ? FREQ_W : DEV_W) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic signed [DEV_W-1:0] s1_dev,
  input  logic [FREQ_W-1:0]       s1_centre,
  output logic                    s2_valid,
  output logic [FREQ_W-1:0]       s2_freq,
  output logic                    s2_hi,
  output logic                    s2_sat
);
  logic signed [SUM_W-1:0] centre_ext, dev_ext, sum;
  logic                    neg, hi;
  logic [FREQ_W-1:0]       freq_nx;

  always_comb begin
    centre_ext = {{(SUM_W-FREQ_W){1'b0}}, s1_centre};
    dev_ext    = {{(SUM_W-DEV_W){s1_dev[DEV_W-1]}}, s1_dev};
    sum        = centre_ext + dev_ext;
    neg        = sum[SUM_W-1];
    hi         = !neg && ($unsigned(sum) > {{(SUM_W-FREQ_W){1'b0}}, HALF_HZ});
    if (neg)     freq_nx = '0;
    else if (hi) freq_nx = HALF_HZ;
    else         freq_nx = sum[FREQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_freq  <= '0;
      s2_hi    <= 1'b0;
      s2_sat   <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_freq <= freq_nx;
        s2_hi   <= hi;
        s2_sat  <= neg | hi;
      end
    end
  end

  // R4: a negative deviation larger than the centre clamps to zero
  p_neg_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_dev[DEV_W-1] && s1_centre == '0 && s1_dev != '0)
      |=> (s2_sat && s2_freq == '0));
  // R5: the clamped frequency never exceeds half the reference
  p_freq_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> (s2_freq <= HALF_HZ));
endmodule

// File: rtl/fm_tw_convert.sv
module fm_tw_convert #(
  parameter int FREQ_W  = 28,
  parameter int WORD_W  = 32,
  parameter int FRAC_W  = 24,
  parameter int K_W     = 29,
  parameter logic [K_W-1:0] K_CONST = '1,
  localparam int PROD_W = FREQ_W + K_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s2_valid,
  input  logic [FREQ_W-1:0] s2_freq,
  input  logic              s2_hi,
  input  logic              s2_sat,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sat
);
  localparam logic [WORD_W-1:0] HALF_WORD = WORD_W'(1) << (WORD_W - 1);

  logic [PROD_W-1:0] prod_nx, s3_prod;
  logic              s3_valid, s3_hi, s3_sat;
  logic [PROD_W:0]   rounded;
  logic [WORD_W-1:0] word_nx;

  always_comb begin
    prod_nx = PROD_W'(s2_freq) * PROD_W'(K_CONST);
    rounded = {1'b0, s3_prod} + ((PROD_W+1)'(1) << (FRAC_W - 1));
    if (s3_hi)       word_nx = HALF_WORD;
    else if (s3_sat) word_nx = '0;
    else             word_nx = rounded[FRAC_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid  <= 1'b0;
      s3_prod   <= '0;
      s3_hi     <= 1'b0;
      s3_sat    <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_sat   <= 1'b0;
    end else begin
      s3_valid  <= s2_valid;
      out_valid <= s3_valid;
      if (s2_valid) begin
        s3_prod <= prod_nx;
        s3_hi   <= s2_hi;
        s3_sat  <= s2_sat;
      end
      if (s3_valid) begin
        out_word <= word_nx;
        out_sat  <= s3_sat;
      end
    end
  end

  // R3: an unclamped word stays within one step of the Nyquist word
  p_word_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word <= HALF_WORD + 1'b1));
  // R5: a clamped result is one of the two limit words
  p_sat_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sat) |-> (out_word == '0 || out_word == HALF_WORD));
endmodule

// File: rtl/fm_tuning_word.sv
module fm_tuning_word #(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 16,
  parameter int FREQ_W   = 28,
  parameter int WORD_W   = 32,
  parameter int FRAC_W   = 24,
  parameter longint unsigned REF_HZ = 180_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [FREQ_W-1:0]   in_centre,
  input  logic [GAIN_W-1:0]   in_gain,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_word,
  output logic                out_sat
);
  import fm_tw_pkg::*;

  localparam int DEV_W = SAMPLE_W + GAIN_W + 1;
  localparam longint unsigned K_VAL = tw_scale_const(REF_HZ, WORD_W, FRAC_W);
  localparam int K_W = $clog2(K_VAL + 1);
  localparam logic [FREQ_W-1:0] HALF_HZ = FREQ_W'(REF_HZ / 2);
  localparam int LATENCY = 4;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic                    s1_valid, s2_valid, s2_hi, s2_sat;
  logic signed [DEV_W-1:0] s1_dev;
  logic [FREQ_W-1:0]       s1_centre, s2_freq;

  fm_tw_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FREQ_W(FREQ_W)) u_scale (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_gain(in_gain), .in_centre(in_centre),
    .s1_valid(s1_valid), .s1_dev(s1_dev), .s1_centre(s1_centre));

  fm_tw_clamp #(.FREQ_W(FREQ_W), .DEV_W(DEV_W), .HALF_HZ(HALF_HZ)) u_clamp (
    .clk(clk), .rst_n(rst_int_n), .s1_valid(s1_valid), .s1_dev(s1_dev),
    .s1_centre(s1_centre), .s2_valid(s2_valid), .s2_freq(s2_freq),
    .s2_hi(s2_hi), .s2_sat(s2_sat));

  fm_tw_convert #(.FREQ_W(FREQ_W), .WORD_W(WORD_W), .FRAC_W(FRAC_W), .K_W(K_W),
                  .K_CONST(K_W'(K_VAL))) u_conv (
    .clk(clk), .rst_n(rst_int_n), .s2_valid(s2_valid), .s2_freq(s2_freq),
    .s2_hi(s2_hi), .s2_sat(s2_sat),
    .out_valid(out_valid), .out_word(out_word), .out_sat(out_sat));

  // cycles since reset release, saturating, to gate history-based checks
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)             age <= '0;
    else if (age != 3'(LATENCY)) age <= age + 3'd1;
  end

  // R6: result strobe follows the input strobe by exactly four edges
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age == 3'(LATENCY)) |-> (out_valid == $past(in_valid, 4)));
  // R7: outputs hold while no result is delivered
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_valid |-> ($stable(out_word) && $stable(out_sat)));
  // R8: under reset the outputs are idle
  p_reset_idle_r8: assert property (@(posedge clk)
    !rst_int_n |-> (!out_valid && out_word == '0 && !out_sat));
endmodule

// File: tb/tb_fm_tuning_word.sv
`timescale 1ns/1ps
module tb_fm_tuning_word;
  logic        clk, rst_n, in_valid;
  logic [11:0] in_sample;
  logic [27:0] in_centre;
  logic [15:0] in_gain;
  logic        out_valid, out_sat;
  logic [31:0] out_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam longint K = 64'd400_319_967;

  fm_tuning_word dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_centre(in_centre), .in_gain(in_gain),
    .out_valid(out_valid), .out_word(out_word), .out_sat(out_sat));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected result from R1..R5
  function automatic void model(int code, longint centre, longint gain,
                                output longint word, output longint sat);
    longint f;
    f = centre + longint'(code - 2048) * gain;
    if (f < 0) begin word = 0; sat = 1; end
    else if (f > 64'd90_000_000) begin word = 64'h8000_0000; sat = 1; end
    else begin word = (f * K + 64'd8_388_608) >> 24; sat = 0; end
  endfunction

  task automatic send_one(string req, int code, longint centre, longint gain);
    longint ew, es;
    model(code, centre, gain, ew, es);
    @(negedge clk);
    in_sample = 12'(code); in_centre = 28'(centre); in_gain = 16'(gain);
    in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk({req, " R6 strobe"}, longint'(out_valid), 1);
    chk({req, " word"}, longint'(out_word), ew);
    chk({req, " sat"}, longint'(out_sat), es);
    @(posedge clk); #1;
    chk({req, " R6 single pulse"}, longint'(out_valid), 0);
    chk({req, " R7 word held"}, longint'(out_word), ew);
  endtask

  task automatic test_reset();
    chk("R8 valid", longint'(out_valid), 0);
    chk("R8 word", longint'(out_word), 0);
    chk("R8 sat", longint'(out_sat), 0);
  endtask

  task automatic test_mid_r1();
    send_one("R1 mid-scale", 2048, 14_000_000, 5000);
    chk("R1 mid word exact", longint'(out_word), (64'd14_000_000 * K + 64'd8_388_608) >> 24);
    send_one("R1 full negative", 0, 20_000_000, 100);
    send_one("R1 full positive", 4095, 20_000_000, 100);
  endtask

  task automatic test_linear_r2_r3();
    send_one("R2 positive dev", 2048 + 500, 10_000_000, 100);
    send_one("R2 negative dev", 2048 - 1234, 7_123_456, 77);
    send_one("R2 zero gain", 17, 4_194_304, 0);
    send_one("R3 small freq", 2048 + 3, 0, 1);
    send_one("R3 large gain", 3000, 50_000_000, 40_000);
  endtask

  task automatic test_low_r4();
    send_one("R4 below zero", 0, 100_000, 1000);
    send_one("R4 one below zero", 2047, 0, 1);
  endtask

  task automatic test_high_r5();
    send_one("R5 above half", 4095, 89_990_000, 1000);
    send_one("R5 centre above half", 2048, 200_000_000, 300);
    send_one("R5 exactly half", 2048, 90_000_000, 0);
    chk("R5 half not sat", longint'(out_sat), 0);
    send_one("R5 half plus one", 2049, 90_000_000, 1);
  endtask

  task automatic test_hold_r7();
    logic [31:0] w0;
    logic        s0;
    send_one("R7 setup", 2048 + 900, 30_000_000, 250);
    w0 = out_word; s0 = out_sat;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_sample = 12'(i * 400); in_centre = 28'(i * 9_000_000); in_gain = 16'(i * 5000);
    end
    repeat (5) @(posedge clk);
    #1;
    chk("R7 no valid when idle", longint'(out_valid), 0);
    chk("R7 word unchanged", longint'(out_word), longint'(w0));
    chk("R7 sat unchanged", longint'(out_sat), longint'(s0));
  endtask

  task automatic test_stream_r9();
    localparam int N = 10;
    int     codes [N];
    longint cents [N];
    longint gains [N];
    longint ew, es;
    for (int i = 0; i < N; i++) begin
      codes[i] = (i * 613 + 101) % 4096;
      cents[i] = 1_000_000 + i * 8_500_000;
      gains[i] = (i * 2311) % 65536;
    end
    for (int j = 0; j < N + 4; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        model(codes[j-4], cents[j-4], gains[j-4], ew, es);
        chk("R9 stream strobe", longint'(out_valid), 1);
        chk("R9 stream word", longint'(out_word), ew);
        chk("R9 stream sat", longint'(out_sat), es);
      end
      if (j < N) begin
        in_sample = 12'(codes[j]); in_centre = 28'(cents[j]); in_gain = 16'(gains[j]);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R9 stream ends", longint'(out_valid), 0);
  endtask

  initial begin
    in_valid = 1'b0; in_sample = '0; in_centre = '0; in_gain = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 test_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1 test_reset();
    test_mid_r1();
    test_linear_r2_r3();
    test_low_r4();
    test_high_r5();
    test_hold_r7();
    test_stream_r9();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule